// File: doc/BRIEF.md
# Three-Wire Codec Control Port

This block is the slave side of a three-wire serial control port for an audio codec. A host drives a mode line, a serial clock and a serial data line. All three are synchronised into the system clock domain, and rising edges of the serial clock are detected there. Each group of eight bits forms one byte, sent most significant bit first. A byte sent while the mode line is low is an address byte. A byte sent while the mode line is high is a data byte.

An address byte carries a six-bit device address and a two-bit target code. When the address matches, the port selects itself and decodes the data bytes that follow into the codec's control fields. These fields are the system clock rate, the audio input format, the DC-cancellation filter enable, DAC volume, de-emphasis, DAC mute and converter power. When the address does not match, the port deselects itself.

The fields leave the block as parallel signals. When both pin-mode inputs are high, the codec is under static pin control, and serial writes leave every field unchanged.

Top module: `ctl3w_port`

## Requirements
- R1: Reset sets clk_rate=0, data_fmt=0, dc_filt_en=0, volume=0, deemph=0, dac_mute=0 and pwr_ctl=2'b11 (both converters on).
- R2: A byte received with ser_mode low is an address byte. Bits are taken MSB first on each rising ser_clk. The port selects itself when bits 7:2 equal 6'b000101.
- R3: An address byte whose bits 7:2 differ from 6'b000101 deselects the port. Later data bytes change no field until a matching address byte arrives.
- R4: With target code 2'b10 (address bits 1:0), a data byte sets clk_rate from bits 5:4, data_fmt from bits 3:1 and dc_filt_en from bit 0.
- R5: With target code 2'b00, a data byte whose bits 7:6 are 2'b00 sets volume from bits 5:0.
- R6: With target code 2'b00, a data byte whose bits 7:6 are 2'b10 sets deemph from bits 4:3, dac_mute from bit 2 and pwr_ctl from bits 1:0. In pwr_ctl, bit 1 turns the ADC on and bit 0 turns the DAC on.
- R7: While pin_mode_a and pin_mode_b are both high, data bytes change no field.
- R8: A change of ser_mode discards any partly received byte. The next byte starts from its first bit.
- R9: Target codes 2'b01 and 2'b11, and data bytes whose bits 7:6 are 2'b01 or 2'b11 under target 2'b00, change no field.
- R10: After one matching address byte, any number of data bytes may follow, and each one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_mode_a | input | 1 | First pin-mode select |
| pin_mode_b | input | 1 | Second pin-mode select; when both are high, serial writes are blocked |
| ser_mode | input | 1 | Serial mode line: low for an address byte, high for a data byte |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| clk_rate | output | 2 | System clock rate select |
| data_fmt | output | 3 | Audio serial input format select |
| dc_filt_en | output | 1 | DC-cancellation filter enable |
| volume | output | 6 | DAC volume code |
| deemph | output | 2 | De-emphasis select |
| dac_mute | output | 1 | DAC mute |
| pwr_ctl | output | 2 | Converter power; bit 1 is ADC on, bit 0 is DAC on |

## Verification
The bit counter can lose alignment with the serial stream. When that happens, every later byte is assembled from the wrong bits. The result shows at the ports on the next data byte as a wrong field value, or as a field that does not change, and the error lasts until a mode change realigns the counter. A wrong selection flag shows on the first data byte after an address byte: that byte either fails to land or lands when it should not. A wrong target code shows as a write to the wrong field group. Every field is compared a few system clocks after each byte ends, so each of these faults is caught within one byte of when it arises.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 6'b000101;
  localparam logic [1:0] PWR_RESET = 2'b11;

  typedef enum logic [1:0] {
    TGT_DATA   = 2'b00,
    TGT_RSV_A  = 2'b01,
    TGT_STATUS = 2'b10,
    TGT_RSV_B  = 2'b11
  } tgt_e;

  typedef struct packed {
    logic [1:0] clk_rate;
    logic [2:0] fmt;
    logic       dc_en;
  } status_t;

  typedef struct packed {
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
    logic [1:0] pwr;
  } play_t;

  function automatic logic addr_hits(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: ADDR_W] == DEV_ADDR;
  endfunction

  function automatic status_t status_of(input logic [BYTE_W-1:0] b);
    status_t s;
    s.clk_rate = b[5:4];
    s.fmt      = b[3:1];
    s.dc_en    = b[0];
    return s;
  endfunction

  function automatic play_t play_merge(input play_t cur, input logic [BYTE_W-1:0] b);
    play_t p;
    p = cur;
    case (b[7:6])
      2'b00: p.vol = b[5:0];
      2'b10: begin
        p.deemph = b[4:3];
        p.mute   = b[2];
        p.pwr    = b[1:0];
      end
      default: p = cur;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] flip
);
  logic [LINES-1:0][STAGES-1:0] pipe;
  logic [LINES-1:0]             prev;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe[i] <= '0;
        prev[i] <= 1'b0;
      end else begin
        pipe[i] <= {pipe[i][STAGES-2:0], raw[i]};
        prev[i] <= pipe[i][STAGES-1];
      end
    end
    assign synced[i] = pipe[i][STAGES-1];
    assign rise[i]   = synced[i] & ~prev[i];
    assign flip[i]   = synced[i] ^ prev[i];
  end
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              bit_in,
  input  logic              flush,
  input  logic              mode_hi,
  output logic              byte_done,
  output logic              byte_is_addr,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              at_last;

  assign at_last      = (cnt == LAST);
  assign byte_done    = strobe && !flush && at_last;
  assign byte_val     = {sh, bit_in};
  assign byte_is_addr = !mode_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else if (strobe) begin
      sh  <= {sh[BYTE_W-3:0], bit_in};
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic              byte_is_addr,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              locked,
  output status_t           stat_q,
  output play_t             play_q,
  output logic              selected
);
  tgt_e tgt_q;
  logic data_wr;

  assign data_wr = byte_done && !byte_is_addr && selected && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected <= 1'b0;
      tgt_q    <= TGT_DATA;
    end else if (byte_done && byte_is_addr) begin
      selected <= addr_hits(byte_val);
      tgt_q    <= tgt_e'(byte_val[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      play_q <= '{vol: 6'd0, deemph: 2'd0, mute: 1'b0, pwr: PWR_RESET};
    end else if (data_wr) begin
      case (tgt_q)
        TGT_STATUS: stat_q <= status_of(byte_val);
        TGT_DATA:   play_q <= play_merge(play_q, byte_val);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_mode_a,
  input  logic       pin_mode_b,
  input  logic       ser_mode,
  input  logic       ser_clk,
  input  logic       ser_data,
  output logic [1:0] clk_rate,
  output logic [2:0] data_fmt,
  output logic       dc_filt_en,
  output logic [5:0] volume,
  output logic [1:0] deemph,
  output logic       dac_mute,
  output logic [1:0] pwr_ctl
);
  localparam int LINES = 3;
  localparam int I_DATA = 0;
  localparam int I_CLK  = 1;
  localparam int I_MODE = 2;

  logic [LINES-1:0]  synced, rise, flip;
  logic              byte_done, byte_is_addr, dev_selected, regs_locked;
  logic [BYTE_W-1:0] byte_val;
  status_t           stat_q;
  play_t             play_q;

  assign regs_locked = pin_mode_a && pin_mode_b;

  ctl3w_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({ser_mode, ser_clk, ser_data}),
    .synced(synced), .rise(rise), .flip(flip)
  );

  ctl3w_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .strobe(rise[I_CLK]), .bit_in(synced[I_DATA]),
    .flush(flip[I_MODE]), .mode_hi(synced[I_MODE]),
    .byte_done(byte_done), .byte_is_addr(byte_is_addr), .byte_val(byte_val)
  );

  ctl3w_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .byte_done(byte_done), .byte_is_addr(byte_is_addr), .byte_val(byte_val),
    .locked(regs_locked), .stat_q(stat_q), .play_q(play_q), .selected(dev_selected)
  );

  assign clk_rate   = stat_q.clk_rate;
  assign data_fmt   = stat_q.fmt;
  assign dc_filt_en = stat_q.dc_en;
  assign volume     = play_q.vol;
  assign deemph     = play_q.deemph;
  assign dac_mute   = play_q.mute;
  assign pwr_ctl    = play_q.pwr;
endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_done,
  input logic        byte_is_addr,
  input logic [7:0]  byte_val,
  input logic        dev_selected,
  input logic        regs_locked,
  input logic [16:0] fields
);
  assert_match_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_is_addr && byte_val[7:2] == 6'b000101) |=> dev_selected);

  assert_mismatch_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_is_addr && byte_val[7:2] != 6'b000101) |=> !dev_selected);

  assert_deselected_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_selected |=> $stable(fields));

  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_locked |=> $stable(fields));

  assert_no_byte_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(fields));

  assert_addr_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_is_addr) |=> $stable(fields));
endmodule

bind ctl3w_port ctl3w_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .byte_done(byte_done), .byte_is_addr(byte_is_addr), .byte_val(byte_val),
  .dev_selected(dev_selected), .regs_locked(regs_locked),
  .fields({clk_rate, data_fmt, dc_filt_en, volume, deemph, dac_mute, pwr_ctl})
);

// File: tb/ctl3w_port_tb.sv
module ctl3w_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_mode_a = 1'b0, pin_mode_b = 1'b0;
  logic ser_mode = 1'b0, ser_clk = 1'b0, ser_data = 1'b0;
  logic [1:0] clk_rate, deemph, pwr_ctl;
  logic [2:0] data_fmt;
  logic       dc_filt_en, dac_mute;
  logic [5:0] volume;

  int errors = 0, checks = 0;
  logic done = 1'b0;

  logic [16:0] exp_f;
  logic        m_sel;
  logic [1:0]  m_tgt;

  always #5 clk = ~clk;

  ctl3w_port u_dut (
    .clk(clk), .rst_n(rst_n), .pin_mode_a(pin_mode_a), .pin_mode_b(pin_mode_b),
    .ser_mode(ser_mode), .ser_clk(ser_clk), .ser_data(ser_data),
    .clk_rate(clk_rate), .data_fmt(data_fmt), .dc_filt_en(dc_filt_en),
    .volume(volume), .deemph(deemph), .dac_mute(dac_mute), .pwr_ctl(pwr_ctl)
  );

  // Field vector: rate[16:15] fmt[14:12] dc[11] vol[10:5] deemph[4:3] mute[2] pwr[1:0]
  function automatic logic [16:0] model_next(input logic [16:0] cur, input logic sel,
                                             input logic [1:0] tgt, input logic [7:0] b,
                                             input logic locked);
    logic [16:0] n;
    n = cur;
    if (sel && !locked) begin
      if (tgt == 2'b10) n[16:11] = b[5:0];
      else if (tgt == 2'b00) begin
        if (b[7:6] == 2'b00) n[10:5] = b[5:0];
        else if (b[7:6] == 2'b10) n[4:0] = b[4:0];
      end
    end
    return n;
  endfunction

  task automatic check_all(input string tag);
    logic [16:0] act;
    act = {clk_rate, data_fmt, dc_filt_en, volume, deemph, dac_mute, pwr_ctl};
    @(negedge clk);
    checks++;
    if (act !== exp_f) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_f);
    end
  endtask

  task automatic send_byte(input logic m, input logic [7:0] b, input int nbits = 8);
    if (ser_mode != m) begin
      ser_mode = m;
      repeat (4) @(posedge clk);
    end
    for (int i = 7; i > 7 - nbits; i--) begin
      ser_data = b[i];
      repeat (3) @(posedge clk);
      ser_clk = 1'b1;
      repeat (3) @(posedge clk);
      ser_clk = 1'b0;
    end
    repeat (5) @(posedge clk);
  endtask

  task automatic xfer(input logic m, input logic [7:0] b);
    send_byte(m, b);
    if (!m) begin
      m_sel = (b[7:2] == 6'b000101);
      m_tgt = b[1:0];
    end else begin
      exp_f = model_next(exp_f, m_sel, m_tgt, b, pin_mode_a && pin_mode_b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    exp_f = {2'd0, 3'd0, 1'b0, 6'd0, 2'd0, 1'b0, 2'b11};
    m_sel = 1'b0; m_tgt = 2'b00;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    check_all("R1 reset values");

    xfer(1'b0, {6'b000101, 2'b10});
    xfer(1'b1, 8'b00_10_110_1);
    check_all("R4 status write");
    xfer(1'b1, 8'b00_01_011_0);
    check_all("R4 status rewrite");

    xfer(1'b0, {6'b000101, 2'b00});
    check_all("R2 address byte alone");
    xfer(1'b1, 8'b00_101010);
    check_all("R5 volume write");
    xfer(1'b1, 8'b10_0_11_1_01);
    check_all("R6 deemph mute power");
    xfer(1'b1, 8'b00_000111);
    check_all("R10 consecutive data byte");

    xfer(1'b1, 8'b01_111111);
    check_all("R9 sub-select 01 ignored");
    xfer(1'b1, 8'b11_111111);
    check_all("R9 sub-select 11 ignored");
    xfer(1'b0, {6'b000101, 2'b01});
    xfer(1'b1, 8'b00_110011);
    check_all("R9 target 01 ignored");

    xfer(1'b0, {6'b000100, 2'b00});
    xfer(1'b1, 8'b00_111000);
    check_all("R3 mismatched address blocks");
    xfer(1'b1, 8'b10_1_01_0_10);
    check_all("R3 still deselected");
    xfer(1'b0, {6'b000101, 2'b00});
    xfer(1'b1, 8'b00_111000);
    check_all("R3 reselected by match");

    pin_mode_a = 1'b1; pin_mode_b = 1'b1;
    xfer(1'b1, 8'b00_010101);
    check_all("R7 static pin mode blocks write");
    pin_mode_b = 1'b0;
    xfer(1'b1, 8'b00_010101);
    check_all("R7 one pin low allows write");
    pin_mode_a = 1'b0;

    send_byte(1'b1, 8'b00_111111, 5);
    xfer(1'b0, {6'b000101, 2'b00});
    xfer(1'b1, 8'b00_100001);
    check_all("R8 partial byte discarded");

    for (int it = 0; it < 60; it++) begin
      logic [7:0] ab;
      int nd;
      ab[7:2] = ($urandom % 4 != 0) ? 6'b000101 : 6'($urandom);
      ab[1:0] = 2'($urandom);
      if ($urandom % 3 == 0) ab[1:0] = 2'b00;
      pin_mode_a = ($urandom % 6 == 0);
      pin_mode_b = pin_mode_a && ($urandom % 2 == 0);
      xfer(1'b0, ab);
      nd = 1 + ($urandom % 4);
      for (int k = 0; k < nd; k++) begin
        xfer(1'b1, 8'($urandom));
        check_all("R2 R4 R5 R6 R7 R10 random");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule